// File: doc/BRIEF.md
# Multi-Master I2C Byte Controller

This block is the master side of an I2C bus that other masters may share. A host hands it one command at a time: open a transaction, send a byte, receive a byte, or close the transaction. The controller turns each command into open-drain activity on SCL and SDA. The host builds the first byte after a START itself, as the 7-bit address followed by the direction bit. The controller reports the ninth-bit acknowledge, the byte seen on the bus, and whether arbitration was lost.

Both lines pass through a two-flop synchronizer. A START or STOP condition seen on the synchronized lines sets or clears a busy flag, including conditions made by other masters. The controller never starts a transaction while that flag is set.

While it sends a 1, the controller compares the SDA level it samples against the level it released. If SDA reads low, it has lost arbitration. It stops driving SDA, clocks out the rest of the byte and its acknowledge slot, releases both lines and flags the loss. SCL timing comes from a programmable half period in system clocks. A high phase is counted only after SCL is observed high, so a slave can stretch the clock by holding SCL low.

Top module: `i2c_mm_master`

## Requirements
- R1: After reset both line enables (`scl_oe`, `sda_oe`) are 0, so both lines are released. `bus_busy` and `arb_lost` are 0 and `cmd_ready` is 1. A 1 on an enable pulls its line low; the block never drives a line high.
- R2: A START is made by pulling SDA low while SCL is high. A STOP is made by releasing SDA while SCL is high. During byte transfer the controller changes its SDA drive only while it is holding SCL low. A START command issued while the controller owns the bus performs a repeated START.
- R3: `bus_busy` becomes 1 when a START condition is seen on the synchronized lines and 0 when a STOP condition is seen, whichever master made it. A START command waits while `bus_busy` is 1 and no line activity occurs until a STOP has been seen.
- R4: `cmd_op` encodes 0 = START, 1 = WRITE, 2 = READ, 3 = STOP. A command is taken when `cmd_valid` and `cmd_ready` are both 1, and `done` pulses for one cycle when it completes. WRITE sends `cmd_data` MSB first.
- R5: Each byte has a ninth clock. After a WRITE, `ack_rcvd` is 1 when SDA was low on that clock. On a READ, the controller pulls SDA low on the ninth clock when `cmd_nack` = 0 and releases it when `cmd_nack` = 1.
- R6: If SDA reads low on a clock where the controller released SDA to send a 1 in a WRITE, `arb_lost` becomes 1. The controller then stops driving SDA and keeps clocking until the ninth clock of that byte ends, so nine SCL rising edges occur after the START. It then releases both lines, returns to idle and pulses `done`. `arb_lost` clears when the next START command is accepted.
- R7: After releasing SCL, the controller waits until the synchronized SCL reads high before timing the high phase. A slave holding SCL low therefore lengthens the low phase and leaves every high phase at its normal length.
- R8: After any byte, START or repeated START, the controller holds SCL low with SDA released and waits for the next host command. A NACK (`ack_rcvd` = 0) does not make it close the transaction on its own.
- R9: WRITE, READ and STOP commands accepted while the controller does not own the bus complete with a `done` pulse and cause no line activity.
- R10: With no stretching, each SCL low phase of a bit lasts `half_period` clocks. Each high phase lasts `half_period` + 3 clocks, from release to pull-down: two synchronizer stages and one cycle to observe the high level, then `half_period` clocks of counting.
- R11: After a READ, `rd_data` holds the eight SDA samples of that byte, the first sample in bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| half_period | input | DIV_W | SCL half period in system clocks (at least 2) |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be taken |
| cmd_op | input | 2 | 0 START, 1 WRITE, 2 READ, 3 STOP |
| cmd_data | input | 8 | Byte for WRITE |
| cmd_nack | input | 1 | READ: 1 releases SDA on the ninth clock |
| rd_data | output | 8 | Bits sampled during the last byte |
| ack_rcvd | output | 1 | SDA was low on the last ninth clock |
| done | output | 1 | One-cycle completion pulse |
| arb_lost | output | 1 | Arbitration lost in the last transaction |
| bus_busy | output | 1 | A START was seen with no STOP since |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |

## Verification
A command's results are due at its `done` pulse. `rd_data`, `ack_rcvd` and `arb_lost` are all final in the cycle where `done` is 1, so the bench waits for that pulse at a falling clock edge before it reads any of them. A START on the line reaches `bus_busy` three clocks after SDA falls, well inside the START hold of `half_period` clocks, so the busy flag is checked at the START's `done`. The SCL phase lengths of R10 are measured in clock samples on the bus wire and compared against `half_period` and `half_period` + 3.

// File: rtl/i2c_mm_master.sv
module i2c_mm_master #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] half_period,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [1:0]       cmd_op,
  input  logic [7:0]       cmd_data,
  input  logic             cmd_nack,
  output logic [7:0]       rd_data,
  output logic             ack_rcvd,
  output logic             done,
  output logic             arb_lost,
  output logic             bus_busy,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             scl_oe,
  output logic             sda_oe
);
  localparam logic [1:0] OP_START = 2'd0, OP_WRITE = 2'd1, OP_READ = 2'd2, OP_STOP = 2'd3;

  typedef enum logic [3:0] {
    IDLE, WAITFREE, START, HOLD, RS_LOW, RS_HIGHW, RS_SETUP,
    B_LOW, B_HIGHW, B_HIGH, P_LOW, P_HIGHW, P_HIGH, P_FREE
  } st_t;

  st_t              st;
  logic [DIV_W-1:0] cnt;
  logic [8:0]       sh;
  logic [3:0]       bitn;
  logic             rd_mode;
  logic [1:0]       scl_sy, sda_sy;
  logic             scl_q, sda_q;
  logic             scl_s, sda_s, phase_end;

  assign scl_s     = scl_sy[1];
  assign sda_s     = sda_sy[1];
  assign phase_end = (cnt == half_period - 1'b1);
  assign cmd_ready = (st == IDLE) || (st == HOLD);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_sy <= 2'b11; sda_sy <= 2'b11; scl_q <= 1'b1; sda_q <= 1'b1; bus_busy <= 1'b0;
    end else begin
      scl_sy <= {scl_sy[0], scl_i};
      sda_sy <= {sda_sy[0], sda_i};
      scl_q  <= scl_s;
      sda_q  <= sda_s;
      if (scl_s && scl_q && sda_q && !sda_s)      bus_busy <= 1'b1;
      else if (scl_s && scl_q && !sda_q && sda_s) bus_busy <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= IDLE; cnt <= '0; sh <= '1; bitn <= '0; rd_mode <= 1'b0;
      rd_data <= '0; ack_rcvd <= 1'b0; done <= 1'b0; arb_lost <= 1'b0;
      scl_oe <= 1'b0; sda_oe <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        IDLE: begin
          scl_oe <= 1'b0;
          sda_oe <= 1'b0;
          if (cmd_valid) begin
            if (cmd_op == OP_START) begin
              arb_lost <= 1'b0;
              cnt <= '0;
              st <= WAITFREE;
            end else done <= 1'b1;
          end
        end
        WAITFREE: begin
          if (!bus_busy && scl_s && sda_s) begin
            if (phase_end) begin sda_oe <= 1'b1; cnt <= '0; st <= START; end
            else cnt <= cnt + 1'b1;
          end else cnt <= '0;
        end
        START: begin
          if (phase_end) begin scl_oe <= 1'b1; cnt <= '0; done <= 1'b1; st <= HOLD; end
          else cnt <= cnt + 1'b1;
        end
        HOLD: begin
          scl_oe <= 1'b1;
          sda_oe <= 1'b0;
          cnt <= '0;
          if (cmd_valid) begin
            case (cmd_op)
              OP_WRITE: begin sh <= {cmd_data, 1'b1}; rd_mode <= 1'b0; bitn <= '0; st <= B_LOW; end
              OP_READ:  begin sh <= {8'hFF, cmd_nack}; rd_mode <= 1'b1; bitn <= '0; st <= B_LOW; end
              OP_STOP:  st <= P_LOW;
              default:  st <= RS_LOW;
            endcase
          end
        end
        RS_LOW, P_LOW, B_LOW: begin
          if (cnt == '0) sda_oe <= (st == P_LOW) || (st == B_LOW && !sh[8] && !arb_lost);
          if (phase_end) begin
            scl_oe <= 1'b0;
            cnt <= '0;
            st <= (st == RS_LOW) ? RS_HIGHW : (st == P_LOW) ? P_HIGHW : B_HIGHW;
          end else cnt <= cnt + 1'b1;
        end
        RS_HIGHW, P_HIGHW, B_HIGHW: begin
          cnt <= '0;
          if (scl_s) st <= (st == RS_HIGHW) ? RS_SETUP : (st == P_HIGHW) ? P_HIGH : B_HIGH;
        end
        RS_SETUP: begin
          if (phase_end) begin sda_oe <= 1'b1; cnt <= '0; st <= START; end
          else cnt <= cnt + 1'b1;
        end
        B_HIGH: begin
          if (cnt == '0) begin
            if (bitn < 4'd8) rd_data <= {rd_data[6:0], sda_s};
            else ack_rcvd <= !sda_s;
            if (!rd_mode && bitn < 4'd8 && sh[8] && !sda_s) arb_lost <= 1'b1;
          end
          if (phase_end) begin
            cnt <= '0;
            sh <= {sh[7:0], 1'b1};
            done <= (bitn == 4'd8);
            if (bitn != 4'd8) begin
              scl_oe <= 1'b1; bitn <= bitn + 1'b1; st <= B_LOW;
            end else if (arb_lost) begin
              sda_oe <= 1'b0; st <= IDLE;
            end else begin
              scl_oe <= 1'b1; st <= HOLD;
            end
          end else cnt <= cnt + 1'b1;
        end
        P_HIGH: begin
          if (phase_end) begin sda_oe <= 1'b0; cnt <= '0; st <= P_FREE; end
          else cnt <= cnt + 1'b1;
        end
        P_FREE: begin
          if (phase_end) begin cnt <= '0; done <= 1'b1; st <= IDLE; end
          else cnt <= cnt + 1'b1;
        end
        default: st <= IDLE;
      endcase
    end
  end

  assert_sda_moves_in_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == B_LOW && !$stable(sda_oe)) |-> (scl_oe && $past(scl_oe)));

  assert_start_only_when_free_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == START && $past(st) == WAITFREE) |-> !$past(bus_busy));

  assert_lost_releases_sda_R6: assert property (@(posedge clk) disable iff (!rst_n)
    arb_lost |-> !sda_oe);

  assert_high_counted_after_seen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == B_HIGH && $past(st) == B_HIGHW) |-> $past(scl_s));

  assert_done_at_rest_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (st == HOLD || st == IDLE));
endmodule

// File: tb/i2c_mm_master_test.sv
module i2c_mm_master_test;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 6;
  localparam logic [6:0] SLV = 7'h3C;
  localparam logic [1:0] C_START = 2'd0, C_WRITE = 2'd1, C_READ = 2'd2, C_STOP = 2'd3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_nack = 1'b0;
  logic [1:0] cmd_op = 2'd0;
  logic [7:0] cmd_data = 8'd0;
  logic cmd_ready, ack_rcvd, done, arb_lost, bus_busy, scl_oe, sda_oe;
  logic [7:0] rd_data;
  logic scl_bus, sda_bus;

  int vectors = 0, miscompares = 0, cyc = 0;
  logic done_seen;

  // slave and second-master models
  logic p_scl = 1'b1, p_sda = 1'b1;
  int   s_bit = 9, s_nbyte = 0, s_hold = 0, s_stretch = 0;
  logic s_act = 1'b0, s_match = 1'b0, s_rw = 1'b0, s_tx = 1'b0, s_ack = 1'b0, s_mack = 1'b0;
  logic [7:0] s_sh = 8'd0, s_got = 8'd0, s_txval = 8'd0;
  logic m2_en = 1'b0, m2_scl = 1'b0, m2_sda = 1'b0;
  logic [7:0] m2_byte = 8'd0;
  int   rises = 0, starts_n = 0, stops_n = 0;
  int   hi_len = 0, lo_len = 0, last_hi = 0, last_lo = 0, hi_min = 999, hi_max = 0, lo_max = 0;

  function automatic logic bit_low(input logic [7:0] b, input int i);
    return (i >= 0 && i <= 7) ? !b[7-i] : 1'b0;
  endfunction
  function automatic logic exp_ack(input logic [6:0] a);
    return a == SLV;
  endfunction
  function automatic logic exp_mack(input logic last);
    return !last;
  endfunction

  assign scl_bus = !(scl_oe || s_hold != 0 || m2_scl);
  assign sda_bus = !(sda_oe || s_ack || (s_tx && bit_low(s_txval, s_bit)) ||
                     (m2_en && bit_low(m2_byte, s_bit)) || m2_sda);

  i2c_mm_master #(.DIV_W(16)) uut (
    .clk(clk), .rst_n(rst_n), .half_period(16'(HALF)),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_data(cmd_data),
    .cmd_nack(cmd_nack), .rd_data(rd_data), .ack_rcvd(ack_rcvd), .done(done),
    .arb_lost(arb_lost), .bus_busy(bus_busy), .scl_i(scl_bus), .sda_i(sda_bus),
    .scl_oe(scl_oe), .sda_oe(sda_oe));

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    p_scl <= scl_bus;
    p_sda <= sda_bus;
    if (s_hold != 0) s_hold <= s_hold - 1;
    if (p_scl && scl_bus && p_sda && !sda_bus) begin
      s_bit <= 9; s_nbyte <= 0; s_act <= 1'b1; s_ack <= 1'b0; s_tx <= 1'b0; s_match <= 1'b0;
      starts_n <= starts_n + 1; rises <= 0;
    end else if (p_scl && scl_bus && !p_sda && sda_bus) begin
      s_act <= 1'b0; s_ack <= 1'b0; s_tx <= 1'b0; stops_n <= stops_n + 1;
    end else if (!p_scl && scl_bus) begin
      rises <= rises + 1;
      if (s_act && s_bit < 8) s_sh <= {s_sh[6:0], sda_bus};
      else if (s_act && s_bit == 8 && s_tx) s_mack <= !sda_bus;
    end else if (s_act && p_scl && !scl_bus) begin
      if (s_bit == 9) s_bit <= 0;
      else if (s_bit == 7) begin
        s_bit <= 8;
        if (s_nbyte == 0) begin
          s_match <= (s_sh[7:1] == SLV); s_rw <= s_sh[0]; s_ack <= (s_sh[7:1] == SLV);
        end else if (!s_tx) begin
          s_ack <= s_match;
          if (s_match) s_got <= s_sh;
        end
      end else if (s_bit == 8) begin
        s_bit <= 0; s_nbyte <= s_nbyte + 1; s_ack <= 1'b0;
        s_tx <= s_match && s_rw && (s_nbyte == 0 || s_mack);
      end else begin
        s_bit <= s_bit + 1;
        if (s_bit == 2 && s_stretch != 0) s_hold <= s_stretch;
      end
    end
  end

  always @(posedge clk) begin
    if (scl_bus) begin
      hi_len <= hi_len + 1;
      if (!p_scl && lo_len != 0) begin
        last_lo <= lo_len;
        if (lo_len > lo_max) lo_max <= lo_len;
      end
      lo_len <= 0;
    end else begin
      lo_len <= lo_len + 1;
      if (p_scl && hi_len != 0) begin
        last_hi <= hi_len;
        if (hi_len < hi_min) hi_min <= hi_len;
        if (hi_len > hi_max) hi_max <= hi_len;
      end
      hi_len <= 0;
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 190000) begin
      miscompares++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] op, input logic [7:0] d, input logic nk);
    int guard;
    @(negedge clk);
    cmd_op = op; cmd_data = d; cmd_nack = nk; cmd_valid = 1'b1;
    guard = 0;
    while (!cmd_ready && guard < 5000) begin @(negedge clk); guard++; end
    @(negedge clk);
    cmd_valid = 1'b0;
    guard = 0;
    while (!done && guard < 20000) begin @(negedge clk); guard++; end
    done_seen = done;
    @(negedge clk);
  endtask

  task automatic m2_stop();
    @(negedge clk); m2_scl = 1'b1;
    repeat (10) @(negedge clk); m2_sda = 1'b1;
    repeat (10) @(negedge clk); m2_scl = 1'b0;
    repeat (10) @(negedge clk); m2_sda = 1'b0;
  endtask

  task automatic arb_case(input logic [7:0] ua, input logic [7:0] mb);
    logic saw;
    int guard;
    m2_byte = mb; m2_en = 1'b1;
    issue(C_START, 8'h00, 1'b0);
    issue(C_WRITE, ua, 1'b0);
    chk("R6 done after lost byte", done_seen, 1);
    chk("R6 arb_lost flag", arb_lost, 1);
    chk("R6 lines released", {scl_oe, sda_oe}, 0);
    chk("R6 nine clocks", rises, 9);
    chk("R3 busy held by other master", bus_busy, 1);
    m2_en = 1'b0;
    @(negedge clk); cmd_op = C_START; cmd_valid = 1'b1;
    @(negedge clk); cmd_valid = 1'b0;
    saw = 1'b0;
    for (int i = 0; i < 100; i++) begin @(negedge clk); saw |= done | sda_oe | scl_oe; end
    chk("R3 START waits while busy", saw, 0);
    m2_stop();
    guard = 0;
    while (!done && guard < 2000) begin @(negedge clk); guard++; end
    chk("R3 START after STOP", done, 1);
    chk("R6 arb_lost cleared", arb_lost, 0);
    @(negedge clk);
    issue(C_WRITE, {SLV, 1'b0}, 1'b0);
    chk("R5 ack after recovery", ack_rcvd, 1);
    issue(C_STOP, 8'h00, 1'b0);
  endtask

  initial begin
    void'($urandom(32'h5EED));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 enables released", {scl_oe, sda_oe}, 0);
    chk("R1 ready/busy/lost", {cmd_ready, bus_busy, arb_lost}, 3'b100);

    issue(C_WRITE, 8'h55, 1'b0);
    chk("R9 idle write done", done_seen, 1);
    chk("R9 no bus activity", {starts_n[7:0], rises[7:0], scl_oe, sda_oe}, 0);

    issue(C_START, 8'h00, 1'b0);
    chk("R4 START done", done_seen, 1);
    chk("R2 START seen on bus", starts_n, 1);
    chk("R3 busy after START", bus_busy, 1);
    issue(C_WRITE, {SLV, 1'b0}, 1'b0);
    chk("R5 address ack", ack_rcvd, 1);
    chk("R10 high phase", last_hi, HALF + 3);
    chk("R10 low phase", last_lo, HALF);
    issue(C_WRITE, 8'hA5, 1'b0);
    chk("R4 byte written", s_got, 8'hA5);

    s_stretch = 20; hi_min = 999; hi_max = 0; lo_max = 0;
    issue(C_WRITE, 8'h3C, 1'b0);
    s_stretch = 0;
    chk("R7 data through stretch", s_got, 8'h3C);
    chk("R7 min high", hi_min, HALF + 3);
    chk("R7 max high", hi_max, HALF + 3);
    chk("R7 stretched low", lo_max >= 20, 1);

    issue(C_START, 8'h00, 1'b0);
    chk("R2 repeated START", starts_n, 2);
    issue(C_WRITE, {SLV, 1'b1}, 1'b0);
    chk("R5 read address ack", ack_rcvd, 1);
    s_txval = 8'hC3;
    issue(C_READ, 8'h00, 1'b0);
    chk("R11 read byte", rd_data, 8'hC3);
    chk("R5 master ACK", s_mack, exp_mack(1'b0));
    s_txval = 8'h5A;
    issue(C_READ, 8'h00, 1'b1);
    chk("R11 last read byte", rd_data, 8'h5A);
    chk("R5 master NACK", s_mack, exp_mack(1'b1));
    issue(C_STOP, 8'h00, 1'b0);
    chk("R3 idle after STOP", bus_busy, 0);
    chk("R2 STOP seen, lines high", {stops_n[7:0], scl_bus, sda_bus}, {8'd1, 2'b11});

    issue(C_START, 8'h00, 1'b0);
    issue(C_WRITE, {7'h11, 1'b0}, 1'b0);
    chk("R5 NACK on wrong address", ack_rcvd, 0);
    repeat (200) @(negedge clk);
    chk("R8 bus held after NACK", {scl_oe, scl_bus, cmd_ready, bus_busy}, 4'b1011);
    issue(C_STOP, 8'h00, 1'b0);

    arb_case(8'hF0, 8'hE0);
    for (int t = 0; t < 2; t++) begin
      int k;
      logic [7:0] ua, mb, bitk;
      k = 1 + int'($urandom % 6);
      bitk = 8'h80 >> k;
      ua = 8'($urandom) | 8'h80 | bitk;
      mb = (ua & ~((bitk << 1) - 8'd1)) | (8'($urandom) & (bitk - 8'd1));
      arb_case(ua, mb);
    end

    for (int t = 0; t < 8; t++) begin
      logic rw;
      logic [6:0] a;
      int n;
      rw = 1'($urandom);
      a = ($urandom % 4 != 0) ? SLV : (7'h40 | 7'($urandom % 64));
      n = 1 + int'($urandom % 3);
      issue(C_START, 8'h00, 1'b0);
      issue(C_WRITE, {a, rw}, 1'b0);
      chk("R5 random address ack", ack_rcvd, exp_ack(a));
      if (ack_rcvd) begin
        for (int j = 0; j < n; j++) begin
          logic [7:0] d;
          d = 8'($urandom);
          if (!rw) begin
            issue(C_WRITE, d, 1'b0);
            chk("R4 random write byte", s_got, d);
          end else begin
            s_txval = d;
            issue(C_READ, 8'h00, j == n - 1);
            chk("R11 random read byte", rd_data, d);
            chk("R5 random master ack", s_mack, exp_mack(j == n - 1));
          end
        end
      end
      issue(C_STOP, 8'h00, 1'b0);
      chk("R3 free after random STOP", bus_busy, 0);
    end

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule